// File: doc/BRIEF.md
# Edge-Latched Timestamp Capture Unit

This block keeps a free-running 64-bit time counter and records its value whenever an external strobe changes level. Two strobe inputs are provided, typically the transmit and receive start-of-frame indications of an Ethernet PHY. Every input has one capture register for its rising edge and a separate one for its falling edge, so four timestamps are held in total. Each has a hit flag in a status word.

Software reaches the block over a simple word-addressed register bus. The bus has an address, a read strobe, a write strobe, write data, and read data that is registered and valid one cycle after the read strobe. Captures run in one of two modes. In continuous mode every edge overwrites its register. In gated mode a register that holds an unread value ignores further edges until software reads it. A 64-bit value is read as two words. Reading the low word parks the high word in a holding register. Reading the high word returns the parked half, and it also acknowledges the capture and clears its hit flag.

The counter can be stopped and loaded with a new value in two 32-bit halves. It continues from the loaded value once it is re-enabled.

Top module: `tscap_unit`

## Requirements
- R1: After reset the counter is zero and counting, the control word reads 1 (bit 0 run = 1, bit 1 gated = 0), the status word reads 0 and all capture registers read 0.
- R2: While running, the counter rises by exactly one every clock cycle, and the carry passes from bit 31 into bit 32.
- R3: Word 0 is the control word. Writes to the counter words (word 2 low, word 3 high) take effect only while run is 0 and are ignored while run is 1. After run is set again, the counter continues from the loaded value.
- R4: Each strobe input passes through a two-stage synchroniser. The timestamp stored for an edge equals the counter low word returned by a read of word 2 that was issued in the same cycle as the pin change, plus 2.
- R5: Capture index k = 2*input + edge, where edge is 0 for rising and 1 for falling. Its low word sits at word 4+2k and its high word at word 5+2k.
- R6: Each capture sets hit bit k of the status word (word 1).
- R7: In continuous mode (gated = 0), each edge overwrites its capture register even if the previous value was never read.
- R8: In gated mode (gated = 1), a capture register whose hit bit is set keeps its value and ignores edges. After its high word has been read, the next edge is captured.
- R9: Reading a low word (capture or counter) copies the matching high word into a holding register. The next high-word read returns that copy, even if a newer capture has arrived in between.
- R10: Reading a capture's high word clears its hit bit. Reading its low word leaves the hit bit unchanged.
- R11: If a capture and a high-word read of the same register fall in the same cycle, the new value is stored and the hit bit stays set.
- R12: Read data appears on the cycle after the read strobe. Reading an unmapped word returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| latch_in | input | N_LATCH | Asynchronous strobe inputs |
| bus_addr | input | ADDR_W | Word address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |

## Verification
The bench measures the exact synchroniser latency by reading the counter in the same cycle as each pin change. A stage too many or too few would show up as a timestamp off by one. A coherence test loads a new upper counter half between a low-word read and a high-word read of the same capture. A design without the holding register would return the newer high half. The bench lines up a high-word read with a capture in the same cycle; if clearing won that race, the status word would show the flag dropped. Gated mode is checked by sending repeated pulses without reading: an ungated design would replace the first timestamp. Writes issued while the counter is running must be ignored, and a counter loaded just below a 32-bit boundary must carry correctly into the upper word.

// File: rtl/tscap_pkg.sv
package tscap_pkg;
    localparam int CNT_W        = 64;
    localparam int WORD_W       = 32;
    localparam int REG_CTRL     = 0;
    localparam int REG_STAT     = 1;
    localparam int REG_CNT_LO   = 2;
    localparam int REG_CNT_HI   = 3;
    localparam int REG_CAP_BASE = 4;

    typedef struct packed {
        logic              run;
        logic              gated;
        logic [WORD_W-1:0] hold;
        logic [WORD_W-1:0] rdata;
    } bus_regs_t;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;
endpackage

// File: rtl/tscap_edge_sync.sv
module tscap_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              prev;
    } edge_state_t;

    edge_state_t cur_q, nxt_d;

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.sync = {cur_q.sync[STAGES-2:0], pin};
        nxt_d.prev = cur_q.sync[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign rise = cur_q.sync[STAGES-1] & ~cur_q.prev;
    assign fall = ~cur_q.sync[STAGES-1] & cur_q.prev;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise); // R4
endmodule

// File: rtl/tscap_counter.sv
module tscap_counter
    import tscap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              ld_lo,
    input  logic              ld_hi,
    input  logic [WORD_W-1:0] wdata,
    output logic [CNT_W-1:0]  cnt
);
    cnt_state_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (ld_lo || ld_hi) begin
            if (ld_lo) nxt_d.cnt[WORD_W-1:0]     = wdata;
            if (ld_hi) nxt_d.cnt[CNT_W-1:WORD_W] = wdata;
        end else if (run) begin
            nxt_d.cnt = cur_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign cnt = cur_q.cnt;

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !ld_lo && !ld_hi) |=> (cnt == $past(cnt) + CNT_W'(1))); // R2
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !ld_lo && !ld_hi) |=> $stable(cnt)); // R3
endmodule

// File: rtl/tscap_channel.sv
module tscap_channel
    import tscap_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt,
    input  logic             gated,
    input  logic             ack,
    input  logic [CNT_W-1:0] stamp,
    output logic [CNT_W-1:0] val,
    output logic             hit
);
    typedef struct packed {
        logic [CNT_W-1:0] val;
        logic             hit;
    } chan_state_t;

    chan_state_t cur_q, nxt_d;
    logic        fire;

    always_comb begin
        nxt_d = cur_q;
        fire  = evt && (!gated || !cur_q.hit || ack);
        if (fire) begin
            nxt_d.val = stamp;
            nxt_d.hit = 1'b1;
        end else if (ack) begin
            nxt_d.hit = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign val = cur_q.val;
    assign hit = cur_q.hit;

    AST_HIT_ON_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        evt && !gated |=> hit); // R6
    AST_GATED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (gated && hit && !ack) |=> $stable(val)); // R8
    AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !evt) |=> !hit); // R10
    AST_COLLIDE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && evt) |=> (hit && val == $past(stamp))); // R11
endmodule

// File: rtl/tscap_unit.sv
module tscap_unit
    import tscap_pkg::*;
#(
    parameter  int N_LATCH     = 2,
    parameter  int SYNC_STAGES = 2,
    localparam int N_CAP       = 2 * N_LATCH,
    localparam int ADDR_W      = $clog2(REG_CAP_BASE + 2 * N_CAP)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_LATCH-1:0] latch_in,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata
);
    bus_regs_t         cur_q, nxt_d;
    logic [CNT_W-1:0]  cnt;
    logic              ld_lo, ld_hi;
    logic [N_CAP-1:0]  evt, ack, hit;
    logic [CNT_W-1:0]  cap_val [N_CAP];
    int                a;

    tscap_counter i_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (cur_q.run),
        .ld_lo (ld_lo),
        .ld_hi (ld_hi),
        .wdata (bus_wdata),
        .cnt   (cnt)
    );

    for (genvar l = 0; l < N_LATCH; l++) begin : g_latch
        tscap_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (latch_in[l]),
            .rise  (evt[2*l]),
            .fall  (evt[2*l+1])
        );
    end

    for (genvar k = 0; k < N_CAP; k++) begin : g_cap
        assign ack[k] = bus_rd && (int'(bus_addr) == REG_CAP_BASE + 2*k + 1);
        tscap_channel i_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .evt   (evt[k]),
            .gated (cur_q.gated),
            .ack   (ack[k]),
            .stamp (cnt),
            .val   (cap_val[k]),
            .hit   (hit[k])
        );
    end

    always_comb begin
        a     = int'(bus_addr);
        nxt_d = cur_q;
        ld_lo = bus_wr && !cur_q.run && (a == REG_CNT_LO);
        ld_hi = bus_wr && !cur_q.run && (a == REG_CNT_HI);
        if (bus_wr && a == REG_CTRL) begin
            nxt_d.run   = bus_wdata[0];
            nxt_d.gated = bus_wdata[1];
        end
        if (bus_rd) begin
            nxt_d.rdata = '0;
            if (a == REG_CTRL) nxt_d.rdata = {30'b0, cur_q.gated, cur_q.run};
            if (a == REG_STAT) nxt_d.rdata = WORD_W'(hit);
            if (a == REG_CNT_LO) begin
                nxt_d.rdata = cnt[WORD_W-1:0];
                nxt_d.hold  = cnt[CNT_W-1:WORD_W];
            end
            if (a == REG_CNT_HI) nxt_d.rdata = cur_q.hold;
            for (int k = 0; k < N_CAP; k++) begin
                if (a == REG_CAP_BASE + 2*k) begin
                    nxt_d.rdata = cap_val[k][WORD_W-1:0];
                    nxt_d.hold  = cap_val[k][CNT_W-1:WORD_W];
                end
                if (a == REG_CAP_BASE + 2*k + 1) nxt_d.rdata = cur_q.hold;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q     <= '0;
            cur_q.run <= 1'b1;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign bus_rdata = cur_q.rdata;

    AST_RUN_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.run && bus_wr && int'(bus_addr) == REG_CNT_LO) |=>
        (cnt[WORD_W-1:0] == $past(cnt[WORD_W-1:0]) + WORD_W'(1))); // R3
    AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata)); // R12
endmodule

// File: tb/test_tscap_unit.sv
module test_tscap_unit;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  latch_in = '0;
    logic [AW-1:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    int          n_chk = 0;
    int          n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tscap_unit i_tscap_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .latch_in  (latch_in),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // All bus tasks start and end on a falling edge.
    task automatic wr(input int addr, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = AW'(addr); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int addr, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = AW'(addr);
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    // Toggle a pin while reading the counter low word in the same cycle.
    task automatic edge_meas(input int l, input logic lvl, output logic [31:0] c);
        latch_in[l] = lvl;
        rd(2, c);
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_meas(input int l, output logic [31:0] up, output logic [31:0] dn);
        edge_meas(l, 1'b1, up);
        edge_meas(l, 1'b0, dn);
    endtask

    task automatic clear_hits();
        logic [31:0] d;
        for (int k = 0; k < 4; k++) rd(5 + 2*k, d);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(0, d);  check("R1 ctrl", d, 32'h1);
        rd(1, d);  check("R1 status", d, 32'h0);
        rd(4, d);  check("R1 cap0 lo", d, 32'h0);
        rd(11, d); check("R1 cap3 hi", d, 32'h0);
        rd(15, d); check("R12 unmapped", d, 32'h0);
    endtask

    task automatic t_counter();
        logic [31:0] a, b, d;
        rd(2, a); rd(2, b);
        check("R2 step", b, a + 32'd1);
        wr(0, 32'h0);
        wr(2, 32'h0000_1000); wr(3, 32'h0000_00AB);
        rd(2, d); check("R3 load lo", d, 32'h0000_1000);
        rd(3, d); check("R3 load hi", d, 32'h0000_00AB);
        rd(2, d); check("R3 stopped hold", d, 32'h0000_1000);
        wr(0, 32'h1);
        wr(2, 32'h0);
        rd(2, d); check("R3 write ignored when running", d, 32'h0000_1001);
        rd(3, d); check("R9 counter hi snapshot", d, 32'h0000_00AB);
        wr(0, 32'h0);
        wr(2, 32'hFFFF_FFFE); wr(3, 32'h5);
        wr(0, 32'h1);
        rd(2, d); check("R2 pre-carry", d, 32'hFFFF_FFFE);
        rd(2, d); check("R2 pre-carry+1", d, 32'hFFFF_FFFF);
        rd(2, d); check("R2 carry lo", d, 32'h0);
        rd(3, d); check("R2 carry hi", d, 32'h6);
    endtask

    task automatic t_latency_and_map();
        logic [31:0] u0, d0, u1, d1, d, u2, d2;
        wr(0, 32'h0); wr(2, 32'h0); wr(3, 32'h0); wr(0, 32'h1);
        pulse_meas(0, u0, d0);
        rd(1, d); check("R6 status after latch0", d, 32'h3);
        rd(4, d); check("R4 R5 cap0 rise", d, u0 + 32'd2);
        rd(6, d); check("R4 R5 cap1 fall", d, d0 + 32'd2);
        rd(1, d); check("R10 lo read keeps hit", d, 32'h3);
        rd(4, d); rd(5, d); check("R5 cap0 hi", d, 32'h0);
        rd(1, d); check("R10 hi read clears hit", d, 32'h2);
        pulse_meas(1, u1, d1);
        rd(8, d);  check("R5 cap2 rise", d, u1 + 32'd2);
        rd(10, d); check("R5 cap3 fall", d, d1 + 32'd2);
        rd(1, d);  check("R6 status latch1", d, 32'hE);
        pulse_meas(0, u2, d2);
        rd(4, d); check("R7 cap0 overwritten", d, u2 + 32'd2);
        rd(6, d); check("R7 cap1 overwritten", d, d2 + 32'd2);
    endtask

    task automatic t_gated();
        logic [31:0] u, dn, u2, d2, d;
        wr(0, 32'h3);
        clear_hits();
        rd(1, d); check("R10 all cleared", d, 32'h0);
        pulse_meas(1, u, dn);
        pulse_meas(1, u2, d2);
        rd(8, d);  check("R8 cap2 held", d, u + 32'd2);
        rd(10, d); check("R8 cap3 held", d, dn + 32'd2);
        rd(1, d);  check("R8 status held", d, 32'hC);
        rd(8, d); rd(9, d);
        pulse_meas(1, u2, d2);
        rd(8, d);  check("R8 cap2 after ack", d, u2 + 32'd2);
        rd(10, d); check("R8 cap3 unacked", d, dn + 32'd2);
        wr(0, 32'h1);
    endtask

    task automatic t_snapshot();
        logic [31:0] d;
        wr(0, 32'h0);
        wr(2, 32'h50); wr(3, 32'h11);
        latch_in[0] = 1'b1; repeat (4) @(negedge clk);
        rd(4, d); check("R9 cap0 lo", d, 32'h50);
        wr(3, 32'h22);
        latch_in[0] = 1'b0; repeat (4) @(negedge clk);
        latch_in[0] = 1'b1; repeat (4) @(negedge clk);
        rd(5, d); check("R9 hi from holding", d, 32'h11);
        rd(4, d); rd(5, d); check("R9 hi new capture", d, 32'h22);
        latch_in[0] = 1'b0; repeat (4) @(negedge clk);
        wr(0, 32'h1);
    endtask

    task automatic t_collision();
        logic [31:0] d;
        latch_in[0] = 1'b1; repeat (4) @(negedge clk);
        latch_in[0] = 1'b0; repeat (4) @(negedge clk);
        latch_in[0] = 1'b1;
        @(negedge clk); @(negedge clk);
        rd(5, d);
        rd(1, d); check("R11 hit kept on collision", d & 32'h1, 32'h1);
        latch_in[0] = 1'b0; repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_counter();
        t_latency_and_map();
        t_gated();
        t_snapshot();
        t_collision();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule